// File: doc/BRIEF.md
# RC4 Keystream Generator

This block produces the RC4 keystream. It keeps the whole cipher state in one synchronous-read RAM with two ports. That state is a permutation of 2^IDX_W byte values, plus three running indices. When the caller pulses `start`, the block latches the key bytes and the key length. It then writes the identity permutation into the RAM and runs the key-mixing pass. After that it enters generation, where it emits one keystream byte every three clock cycles until the next `start`. Callers XOR the bytes with their data outside the block.

Each iteration takes three cycles: fetch S[i], then fetch S[j], then swap. The final read of one iteration, at address k, overlaps the first two cycles of the next iteration. The two RAM ports divide the work between them:

- Port A is shared between the i and k addresses.
- Port B always follows j.

The key-mixing pass and the generation pass use the same adder. The adder takes the key byte as an operand during key mixing and zero during generation.

Top module: `rc4_keystream_core`

## Requirements
- R1: After reset, `ready` and `ks_valid` are both low, and they stay low until a `start` is accepted.
- R2: A `start` latches `key_in` and `key_len`. `ready` is first high in the cycle after the 1024th rising edge that follows the edge which sampled `start` (256 fill cycles plus 256 three-cycle key-mixing iterations).
- R3: The first `ks_valid` pulse comes after the 1030th rising edge following the edge that sampled `start`.
- R4: Each `ks_valid` pulse lasts exactly one cycle. While `ready` stays high, consecutive pulses are exactly three cycles apart.
- R5: Key byte n is `key_in[8n+7:8n]`. For every key length from 1 to 16, the bytes presented with `ks_valid` equal the RC4 keystream in order.
- R6: The key 4B 65 79 (length 3) yields the keystream EB 9F 77 81. The key 57 69 6B 69 (length 4) yields 60 44 DB 6D.
- R7: Key bytes at positions equal to or above `key_len` have no effect on the keystream.
- R8: A `start` accepted at any time, including during generation, makes `ready` and `ks_valid` low in the following cycle. The whole sequence then reruns with the new key.
- R9: `ks_valid` is never high while `ready` is low.
- R10: `ks_byte` changes only in a cycle in which `ks_valid` is high.
- R11: When both RAM ports write the same address in a swap cycle (i equals j), they write the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch key and length, restart from the identity fill |
| key_in | input | KEY_MAX_BYTES*IDX_W | Key bytes, byte n at bits [IDX_W*n +: IDX_W] |
| key_len | input | $clog2(KEY_MAX_BYTES+1) | Key length in bytes, 1 to KEY_MAX_BYTES |
| ks_byte | output | IDX_W | Current keystream byte |
| ks_valid | output | 1 | One-cycle strobe marking a new keystream byte |
| ready | output | 1 | High while the core is in the generation phase |

## Verification
The assertions check the following on every cycle:

- Strobes stay one cycle wide and three cycles apart.
- No strobe appears before `ready`.
- The output byte holds between strobes.
- A restart drops `ready` at once.
- The key pointer stays below the latched length.
- Coincident port writes agree.

Only the bench scenarios can show that the byte values equal RC4. They also show the exact fill and key-mixing latency, that key bytes past the length are ignored, and that a restart in the middle of a stream yields the new key's stream from its first byte.

// File: rtl/rc4_pkg.sv
`timescale 1ns/1ps
package rc4_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_FILL  = 2'd1,
      PH_MIX   = 2'd2,
      PH_GEN   = 2'd3
   } rc4_phase_e;

   typedef enum logic [1:0] {
      CY_FETCH_I = 2'd0,
      CY_FETCH_J = 2'd1,
      CY_SWAP    = 2'd2
   } rc4_cycle_e;

endpackage

// File: rtl/rc4_perm_ram.sv
`timescale 1ns/1ps
module rc4_perm_ram #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic [AW-1:0] a_addr,
   input  logic          a_we,
   input  logic [DW-1:0] a_wdata,
   output logic [DW-1:0] a_rdata,
   input  logic [AW-1:0] b_addr,
   input  logic          b_we,
   input  logic [DW-1:0] b_wdata,
   output logic [DW-1:0] b_rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   // Both ports return the contents as they were before any write at this edge.
   always_ff @(posedge clk) begin
      a_rdata <= mem[a_addr];
      b_rdata <= mem[b_addr];
      if (a_we) mem[a_addr] <= a_wdata;
      if (b_we) mem[b_addr] <= b_wdata;
   end

endmodule

// File: rtl/rc4_key_pick.sv
`timescale 1ns/1ps
module rc4_key_pick #(
   parameter int MAXB = 16,
   parameter int BW   = 8,
   localparam int LEN_W = $clog2(MAXB + 1),
   localparam int PTR_W = $clog2(MAXB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [MAXB*BW-1:0] key_in,
   input  logic [LEN_W-1:0]  len_in,
   input  logic              step,
   output logic [BW-1:0]     key_byte
);
   logic [BW-1:0]    key_q [MAXB];
   logic [LEN_W-1:0] len_q;
   logic [PTR_W-1:0] ptr_q;
   logic             wrap;

   for (genvar b = 0; b < MAXB; b++) begin : g_byte
      always_ff @(posedge clk) begin
         if (load) key_q[b] <= key_in[b*BW +: BW];
      end
   end

   assign wrap     = (LEN_W'(ptr_q) == len_q - LEN_W'(1));
   assign key_byte = key_q[ptr_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q <= LEN_W'(1);
         ptr_q <= '0;
      end else if (load) begin
         len_q <= len_in;
         ptr_q <= '0;
      end else if (step) begin
         ptr_q <= wrap ? '0 : ptr_q + PTR_W'(1);
      end
   end

   // R7: the pointer never reaches a byte at or past the latched length
   a_r7_ptr_below_len: assert property (@(posedge clk) disable iff (!rst_n)
      LEN_W'(ptr_q) < len_q);

   // R7: a latched length is always legal
   a_r7_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (len_in != '0 && int'(len_in) <= MAXB));

endmodule

// File: rtl/rc4_keystream_core.sv
`timescale 1ns/1ps
module rc4_keystream_core
   import rc4_pkg::*;
#(
   parameter int IDX_W         = 8,
   parameter int KEY_MAX_BYTES = 16,
   localparam int LEN_W        = $clog2(KEY_MAX_BYTES + 1)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start,
   input  logic [KEY_MAX_BYTES*IDX_W-1:0] key_in,
   input  logic [LEN_W-1:0]               key_len,
   output logic [IDX_W-1:0]               ks_byte,
   output logic                           ks_valid,
   output logic                           ready
);
   localparam logic [IDX_W-1:0] IDX_MAX = '1;

   if (IDX_W < 2 || IDX_W > 10) begin : g_bad_width
      $error("rc4_keystream_core: IDX_W must lie in 2..10");
   end
   if (KEY_MAX_BYTES < 2) begin : g_bad_key
      $error("rc4_keystream_core: KEY_MAX_BYTES must be at least 2");
   end

   rc4_phase_e       phase_q;
   rc4_cycle_e       cyc_q;
   logic [IDX_W-1:0] i_q, j_q, k_q, si_q, sk_q, fill_q;
   logic             valid_q, gen_first_q, k_live_q;

   logic [IDX_W-1:0] a_addr, a_wdata, a_rdata;
   logic [IDX_W-1:0] b_addr, b_wdata, b_rdata;
   logic             a_we, b_we;
   logic [IDX_W-1:0] key_byte, key_op, i_next, j_new;
   logic             run, key_step;

   assign run      = (phase_q == PH_MIX) || (phase_q == PH_GEN);
   assign key_step = (phase_q == PH_MIX) && (cyc_q == CY_SWAP) && !start;
   assign key_op   = (phase_q == PH_MIX) ? key_byte : '0;
   assign i_next   = i_q + IDX_W'(1);
   assign j_new    = j_q + a_rdata + key_op;

   rc4_key_pick #(.MAXB(KEY_MAX_BYTES), .BW(IDX_W)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .key_in   (key_in),
      .len_in   (key_len),
      .step     (key_step),
      .key_byte (key_byte)
   );

   rc4_perm_ram #(.AW(IDX_W), .DW(IDX_W)) u_ram (
      .clk     (clk),
      .a_addr  (a_addr),
      .a_we    (a_we),
      .a_wdata (a_wdata),
      .a_rdata (a_rdata),
      .b_addr  (b_addr),
      .b_we    (b_we),
      .b_wdata (b_wdata),
      .b_rdata (b_rdata)
   );

   // Port A: fill writes, then i fetch / k fetch / i write. Port B: j fetch / j write.
   always_comb begin
      a_addr  = i_q;
      a_we    = 1'b0;
      a_wdata = b_rdata;
      b_addr  = j_q;
      b_we    = 1'b0;
      b_wdata = si_q;
      if (!start) begin
         if (phase_q == PH_FILL) begin
            a_addr  = fill_q;
            a_we    = 1'b1;
            a_wdata = fill_q;
         end else if (run) begin
            case (cyc_q)
               CY_FETCH_I: a_addr = i_next;
               CY_FETCH_J: begin
                  a_addr = k_q;
                  b_addr = j_new;
               end
               CY_SWAP: begin
                  a_we = 1'b1;
                  b_we = 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         cyc_q       <= CY_FETCH_I;
         i_q         <= '0;
         j_q         <= '0;
         k_q         <= '0;
         si_q        <= '0;
         sk_q        <= '0;
         fill_q      <= '0;
         valid_q     <= 1'b0;
         gen_first_q <= 1'b0;
         k_live_q    <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (start) begin
            phase_q <= PH_FILL;
            fill_q  <= '0;
         end else begin
            case (phase_q)
               PH_FILL: begin
                  fill_q <= fill_q + IDX_W'(1);
                  if (fill_q == IDX_MAX) begin
                     phase_q <= PH_MIX;
                     cyc_q   <= CY_FETCH_I;
                     i_q     <= IDX_MAX;
                     j_q     <= '0;
                  end
               end
               PH_MIX, PH_GEN: begin
                  case (cyc_q)
                     CY_FETCH_I: begin
                        i_q   <= i_next;
                        cyc_q <= CY_FETCH_J;
                        if (phase_q == PH_GEN) begin
                           k_q         <= si_q + b_rdata;
                           k_live_q    <= !gen_first_q;
                           gen_first_q <= 1'b0;
                        end
                     end
                     CY_FETCH_J: begin
                        j_q   <= j_new;
                        si_q  <= a_rdata;
                        cyc_q <= CY_SWAP;
                     end
                     default: begin
                        cyc_q <= CY_FETCH_I;
                        if (phase_q == PH_GEN && k_live_q) begin
                           sk_q    <= a_rdata;
                           valid_q <= 1'b1;
                        end
                        if (phase_q == PH_MIX && i_q == IDX_MAX) begin
                           phase_q     <= PH_GEN;
                           i_q         <= '0;
                           j_q         <= '0;
                           gen_first_q <= 1'b1;
                           k_live_q    <= 1'b0;
                        end
                     end
                  endcase
               end
               default: ;
            endcase
         end
      end
   end

   assign ks_byte  = sk_q;
   assign ks_valid = valid_q;
   assign ready    = (phase_q == PH_GEN);

   // R9: no strobe outside generation
   a_r9_quiet_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !ks_valid);

   // R4: strobes last one cycle
   a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      ks_valid |=> !ks_valid);

   // R4: strobes repeat every three cycles during generation
   a_r4_period: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && $past(ready, 3) && $past(ks_valid, 3)) |-> ks_valid);

   // R8: restart drops the flags at once
   a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!ready && !ks_valid));

   // R10: output byte holds between strobes
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ks_byte) |-> ks_valid);

   // R11: coincident swap writes carry one value
   a_r11_swap_agree: assert property (@(posedge clk) disable iff (!rst_n)
      (a_we && b_we && a_addr == b_addr) |-> (a_wdata == b_wdata));

endmodule

// File: tb/rc4_keystream_core_tb.sv
`timescale 1ns/1ps
module rc4_keystream_core_tb;

   typedef logic [7:0] key_t [16];

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [127:0] key_in = '0;
   logic [4:0]   key_len = 5'd1;
   logic [7:0]   ks_byte;
   logic         ks_valid;
   logic         ready;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit wd_hit = 1'b0;
   bit done = 1'b0;
   bit mon_on = 1'b0;

   logic [7:0] exp_q [$];
   logic [7:0] got [64];
   int         got_cyc [64];
   int         got_n = 0;

   always #2 clk = ~clk;

   rc4_keystream_core u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .key_in   (key_in),
      .key_len  (key_len),
      .ks_byte  (ks_byte),
      .ks_valid (ks_valid),
      .ready    (ready)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // Behavioural RC4 model: pushes the first n keystream bytes.
   task automatic push_model(input key_t k, input int len, input int n);
      logic [7:0] s [256];
      logic [7:0] t;
      int j, i, kk;
      for (int x = 0; x < 256; x++) s[x] = 8'(x);
      j = 0;
      for (int x = 0; x < 256; x++) begin
         j = (j + int'(s[x]) + int'(k[x % len])) % 256;
         t = s[x]; s[x] = s[j]; s[j] = t;
      end
      i = 0; j = 0;
      for (int m = 0; m < n; m++) begin
         i = (i + 1) % 256;
         j = (j + int'(s[i])) % 256;
         t = s[i]; s[i] = s[j]; s[j] = t;
         kk = (int'(s[i]) + int'(s[j])) % 256;
         exp_q.push_back(s[kk]);
      end
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && mon_on && ks_valid && exp_q.size() > 0) begin
         logic [7:0] e;
         e = exp_q.pop_front();
         check(ks_byte == e, "R5 keystream byte", ks_byte, e);
         if (got_n < 64) begin
            got[got_n]     = ks_byte;
            got_cyc[got_n] = cyc;
            got_n++;
         end
      end
   end

   task automatic run_key(input key_t k, input int len, input int n, input bit restart_chk);
      int cnt, rdy_at, val_at;
      bit early;
      @(posedge clk);
      mon_on = 1'b0;
      @(negedge clk);
      exp_q.delete();
      got_n = 0;
      push_model(k, len, n);
      for (int b = 0; b < 16; b++) key_in[b*8 +: 8] = k[b];
      key_len = 5'(len);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      mon_on = 1'b1;
      if (restart_chk)
         check(!ready && !ks_valid, "R8 flags after restart", {ready, ks_valid}, 0);
      cnt = 0; rdy_at = -1; val_at = -1; early = 1'b0;
      while (exp_q.size() > 0 && !wd_hit) begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
         if (ready && rdy_at < 0) rdy_at = cnt;
         if (ks_valid && val_at < 0) val_at = cnt;
         if (!ready && ks_valid) early = 1'b1;
      end
      check(rdy_at == 1024, "R2 ready latency", rdy_at, 1024);
      check(val_at == 1030, "R3 first strobe latency", val_at, 1030);
      check(!early, "R9 strobe before ready", early, 0);
      check(got_n == n, "R5 byte count", got_n, n);
      for (int m = 1; m < got_n; m++)
         check(got_cyc[m] - got_cyc[m-1] == 3, "R4 strobe spacing",
               got_cyc[m] - got_cyc[m-1], 3);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      wd_hit = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_up();
   end

   initial begin
      key_t k;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(!ready, "R1 ready after reset", ready, 0);
      check(!ks_valid, "R1 valid after reset", ks_valid, 0);

      // R6: short ASCII key
      for (int b = 0; b < 16; b++) k[b] = 8'h00;
      k[0] = 8'h4B; k[1] = 8'h65; k[2] = 8'h79;
      run_key(k, 3, 8, 1'b0);
      check(got[0] == 8'hEB, "R6 Key byte0", got[0], 8'hEB);
      check(got[1] == 8'h9F, "R6 Key byte1", got[1], 8'h9F);
      check(got[2] == 8'h77, "R6 Key byte2", got[2], 8'h77);
      check(got[3] == 8'h81, "R6 Key byte3", got[3], 8'h81);

      // R7: garbage beyond key_len, restarted while generating (R8)
      for (int b = 0; b < 16; b++) k[b] = 8'hA5 ^ 8'(b * 29);
      k[0] = 8'h57; k[1] = 8'h69; k[2] = 8'h6B; k[3] = 8'h69;
      run_key(k, 4, 8, 1'b1);
      check(got[0] == 8'h60, "R7 Wiki byte0", got[0], 8'h60);
      check(got[1] == 8'h44, "R7 Wiki byte1", got[1], 8'h44);
      check(got[2] == 8'hDB, "R7 Wiki byte2", got[2], 8'hDB);
      check(got[3] == 8'h6D, "R6 Wiki byte3", got[3], 8'h6D);

      // R5: longest key
      for (int b = 0; b < 16; b++) k[b] = 8'(b * 17 + 3);
      run_key(k, 16, 20, 1'b1);

      // R5: single-byte key
      for (int b = 0; b < 16; b++) k[b] = 8'hFF;
      k[0] = 8'h00;
      run_key(k, 1, 12, 1'b1);

      // R8: restart in the middle of a stream, then check the new stream from its first byte
      repeat (7) @(negedge clk);
      for (int b = 0; b < 16; b++) k[b] = 8'(200 - b * 7);
      run_key(k, 9, 10, 1'b1);

      finish_up();
   end

endmodule